// File: doc/BRIEF.md
# Multi-Channel Sample History Buffer

This block keeps a short rolling history of samples from several sampler channels. Each channel has its own circular set of slots. All channels share one slot pointer. When a one-cycle tick pulse arrives, the block takes a snapshot of every lane of the sample input. It then writes the lanes one after another into the current slot, one channel per clock cycle. When the last channel has been written, the slot pointer moves forward by one. With the default settings there are 8 channels of 64 byte-wide slots. At one tick per second, that holds about the last minute of data for each channel.

A host can read any channel and slot at any cycle, with no regard to when the sampler writes. The read port is registered. The memory has one write-only port and one read-only port, and both run on the same clock. If a read addresses the location being written on the same edge, the write data is forwarded to the read output, so the host always gets a defined value.

A status output gives the index of the slot that was completed most recently, together with a flag that says whether any slot has been completed yet. From these the host can find the newest and oldest entries of the history.

Top module: `shist_buf`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o` and `last_valid_o` are 0. The slot pointer restarts at 0, so the first sequence after reset writes slot 0.
- R2: A tick sampled at a clock edge while the block is idle starts a write sequence. `busy_o` is 1 after that edge and for exactly 8 cycles. Channels 0 to 7 are written in ascending order, one on each of the 8 edges that follow the tick edge.
- R3: Channel k stores lane k of `samples_i` (bits [8k+7:8k]) as it was sampled on the tick edge. Changes on `samples_i` during the sequence have no effect.
- R4: A tick that arrives while `busy_o` is 1 is ignored. It neither restarts nor extends the sequence, and the slot pointer advances only once.
- R5: On the edge that writes the last channel, the slot pointer advances by one. On the same edge, `last_slot_o` takes the index of the slot just filled and `last_valid_o` becomes 1.
- R6: The slot pointer wraps from 63 to 0. After the wrap, slot 0 is overwritten with the newest data.
- R7: The memory address is {channel, slot}. A read presented at one edge shows the stored byte on `rd_data_o` after that edge, so read latency is one cycle. Reads are allowed in any cycle, including during a sequence.
- R8: If a read addresses the location being written on the same edge, `rd_data_o` after that edge equals the byte being written.
- R9: Reset does not clear the stored samples. Data written before reset can still be read after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse that requests a new history slot |
| samples_i | input | 64 | One byte lane for each channel; lane k is bits [8k+7:8k] |
| rd_ch_i | input | 3 | Channel to read |
| rd_slot_i | input | 6 | Slot to read |
| rd_data_o | output | 8 | Read data, one cycle after the address |
| busy_o | output | 1 | A write sequence is in progress |
| last_slot_o | output | 6 | Most recently completed slot |
| last_valid_o | output | 1 | At least one slot has been completed since reset |

## Verification
Suppose the channel counter is wrong. Data then lands in the wrong channel, and this shows up on the first host read of an affected location, which can be a single cycle after the bad write. A broken sequencer state shows up within the same tick, as a `busy_o` window that is not 8 cycles long. A slot pointer that skips or fails to wrap is exposed at the next completion, through `last_slot_o`, and through reads that expect the newest data at the following slot. A faulty bypass shows up only in the cycle of a same-address collision, which returns the old byte. The bench therefore aims a read at every channel exactly on its write edge.

// File: rtl/shist_pkg.sv
package shist_pkg;
  parameter int unsigned SH_NUM_CH = 8;
  parameter int unsigned SH_DEPTH  = 64;
  parameter int unsigned SH_DW     = 8;
endpackage

// File: rtl/shist_seq.sv
module shist_seq #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DW     = 8,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned SLOT_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [NUM_CH*DW-1:0]   samples_i,
  output logic                   we_o,
  output logic [CH_W+SLOT_W-1:0] waddr_o,
  output logic [DW-1:0]          wdata_o,
  output logic                   busy_o,
  output logic [SLOT_W-1:0]      last_slot_o,
  output logic                   last_valid_o
);
  localparam logic [CH_W-1:0]   LAST_CH  = CH_W'(NUM_CH - 1);
  localparam logic [SLOT_W-1:0] LAST_SLT = SLOT_W'(DEPTH - 1);

  logic [DW-1:0] lane_w [NUM_CH];
  logic [DW-1:0] snap_q [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lane
      assign lane_w[g] = samples_i[g*DW +: DW];
    end
  endgenerate

  logic              active_q, active_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SLOT_W-1:0] lslot_q, lslot_d;
  logic              lvalid_q, lvalid_d;
  logic              start, finish;

  always_comb begin
    start    = tick_i && !active_q;
    finish   = active_q && (ch_q == LAST_CH);
    active_d = active_q;
    ch_d     = ch_q;
    slot_d   = slot_q;
    lslot_d  = lslot_q;
    lvalid_d = lvalid_q;
    if (start) begin
      active_d = 1'b1;
      ch_d     = '0;
    end else if (finish) begin
      active_d = 1'b0;
      slot_d   = (slot_q == LAST_SLT) ? '0 : slot_q + SLOT_W'(1);
      lslot_d  = slot_q;
      lvalid_d = 1'b1;
    end else if (active_q) begin
      ch_d = ch_q + CH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ch_q     <= '0;
      slot_q   <= '0;
      lslot_q  <= '0;
      lvalid_q <= 1'b0;
    end else begin
      active_q <= active_d;
      ch_q     <= ch_d;
      slot_q   <= slot_d;
      lslot_q  <= lslot_d;
      lvalid_q <= lvalid_d;
    end
  end

  // Snapshot register: data path only, loaded when a sequence starts
  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < NUM_CH; i++) snap_q[i] <= lane_w[i];
    end
  end

  assign we_o         = active_q;
  assign waddr_o      = {ch_q, slot_q};
  assign wdata_o      = snap_q[ch_q];
  assign busy_o       = active_q;
  assign last_slot_o  = lslot_q;
  assign last_valid_o = lvalid_q;

  p_start_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> ch_q == '0);
  p_ch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && ch_q != LAST_CH) |=> (active_q && ch_q == $past(ch_q) + CH_W'(1)));
  p_tick_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tick_i && ch_q != LAST_CH) |=> ch_q != '0);
  p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (slot_q == (($past(slot_q) == LAST_SLT) ? '0 : $past(slot_q) + SLOT_W'(1))));
  p_last_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (lslot_q == $past(slot_q) && lvalid_q));
  p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active_q) |-> $stable(slot_q));
endmodule

// File: rtl/shist_mem.sv
module shist_mem #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/shist_bypass.sv
module shist_bypass #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] rd_data_o
);
  logic          hit_d, hit_q;
  logic [DW-1:0] fwd_q;

  always_comb hit_d = we_i && (waddr_i == raddr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  always_ff @(posedge clk) begin
    if (hit_d) fwd_q <= wdata_i;
  end

  assign rd_data_o = hit_q ? fwd_q : mem_rdata_i;

  p_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && waddr_i == raddr_i) |=> rd_data_o == $past(wdata_i));
endmodule

// File: rtl/shist_buf.sv
module shist_buf
  import shist_pkg::*;
#(
  parameter int unsigned NUM_CH = SH_NUM_CH,
  parameter int unsigned DEPTH  = SH_DEPTH,
  parameter int unsigned DW     = SH_DW,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned SLOT_W = $clog2(DEPTH),
  localparam int unsigned AW     = CH_W + SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NUM_CH*DW-1:0] samples_i,
  input  logic [CH_W-1:0]      rd_ch_i,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  output logic [DW-1:0]        rd_data_o,
  output logic                 busy_o,
  output logic [SLOT_W-1:0]    last_slot_o,
  output logic                 last_valid_o
);
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic [AW-1:0] raddr;
  logic [DW-1:0] mem_rdata;

  assign raddr = {rd_ch_i, rd_slot_i};

  shist_seq #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .samples_i    (samples_i),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .busy_o       (busy_o),
    .last_slot_o  (last_slot_o),
    .last_valid_o (last_valid_o)
  );

  shist_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  shist_bypass #(.AW(AW), .DW(DW)) u_byp (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (we),
    .waddr_i     (waddr),
    .wdata_i     (wdata),
    .raddr_i     (raddr),
    .mem_rdata_i (mem_rdata),
    .rd_data_o   (rd_data_o)
  );

  p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $changed(last_slot_o) || last_slot_o == $past(last_slot_o) && last_valid_o);
endmodule

// File: tb/tb_shist_buf.sv
module tb_shist_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic [63:0] samples_i;
  logic [2:0]  rd_ch_i;
  logic [5:0]  rd_slot_i;
  logic [7:0]  rd_data_o;
  logic        busy_o;
  logic [5:0]  last_slot_o;
  logic        last_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] model [8][64];
  int         cur_slot;
  int         seq_no = 0;

  always #4 clk = ~clk;

  shist_buf dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .samples_i(samples_i),
    .rd_ch_i(rd_ch_i), .rd_slot_i(rd_slot_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .last_slot_o(last_slot_o), .last_valid_o(last_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] make_samples(input int n);
    logic [63:0] s;
    for (int k = 0; k < 8; k++) s[k*8 +: 8] = 8'((n * 13 + k * 29 + 7) & 8'hff);
    return s;
  endfunction

  // Starts and ends at a negedge; runs one full sequence
  task automatic run_tick(input logic [63:0] s);
    samples_i = s;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    samples_i = ~s;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 8; k++) model[k][cur_slot] = s[k*8 +: 8];
    cur_slot = (cur_slot + 1) % 64;
    seq_no++;
  endtask

  task automatic rd_check(input int ch, input int slot, input logic [7:0] exp, input string req);
    rd_ch_i = 3'(ch);
    rd_slot_i = 6'(slot);
    @(negedge clk);
    chk(rd_data_o == exp, req, rd_data_o, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    chk(last_valid_o == 1'b0, "R1 valid in reset", last_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && last_valid_o == 1'b0, "R1 after release", {busy_o, last_valid_o}, 0);
    cur_slot = 0;
  endtask

  task automatic t_first_seq;
    logic [63:0] s;
    int busy_cnt;
    s = make_samples(seq_no);
    samples_i = s;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    samples_i = ~s;
    busy_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      if (busy_o) busy_cnt++;
      @(negedge clk);
    end
    chk(busy_cnt == 8, "R2 busy length", busy_cnt, 8);
    chk(busy_o == 1'b0, "R2 busy drops", busy_o, 0);
    for (int k = 0; k < 8; k++) model[k][cur_slot] = s[k*8 +: 8];
    chk(last_slot_o == 6'(cur_slot) && last_valid_o, "R1 R5 first slot is 0", last_slot_o, cur_slot);
    cur_slot = (cur_slot + 1) % 64;
    seq_no++;
    for (int k = 0; k < 8; k++) rd_check(k, 0, model[k][0], "R3 R7 lane to channel");
  endtask

  task automatic t_ignore_tick;
    logic [63:0] s;
    int start_slot;
    start_slot = cur_slot;
    s = make_samples(seq_no);
    samples_i = s;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    samples_i = ~s;
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0, "R4 no extension", busy_o, 0);
    @(negedge clk);
    chk(busy_o == 1'b0, "R4 no restart", busy_o, 0);
    chk(last_slot_o == 6'(start_slot), "R4 R5 one advance", last_slot_o, start_slot);
    for (int k = 0; k < 8; k++) model[k][cur_slot] = s[k*8 +: 8];
    cur_slot = (cur_slot + 1) % 64;
    seq_no++;
    run_tick(make_samples(seq_no));
    chk(last_slot_o == 6'(start_slot + 1), "R4 next slot", last_slot_o, start_slot + 1);
    for (int k = 0; k < 8; k++) rd_check(k, start_slot, model[k][start_slot], "R3 R4 snapshot kept");
  endtask

  task automatic t_bypass;
    logic [63:0] s;
    int slot;
    slot = cur_slot;
    s = make_samples(seq_no);
    samples_i = s;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    samples_i = ~s;
    for (int k = 0; k < 8; k++) begin
      rd_ch_i = 3'(k);
      rd_slot_i = 6'(slot);
      @(negedge clk);
      chk(rd_data_o == s[k*8 +: 8], "R8 same-edge forward", rd_data_o, s[k*8 +: 8]);
    end
    for (int k = 0; k < 8; k++) model[k][slot] = s[k*8 +: 8];
    cur_slot = (cur_slot + 1) % 64;
    seq_no++;
    rd_check(0, 0, model[0][0], "R7 read older slot");
  endtask

  task automatic t_wrap;
    int bad;
    bad = 0;
    while (cur_slot != 0) begin
      int exp_last;
      exp_last = cur_slot;
      run_tick(make_samples(seq_no));
      if (last_slot_o != 6'(exp_last)) bad++;
    end
    chk(bad == 0, "R5 last slot tracking", bad, 0);
    chk(last_slot_o == 6'd63, "R6 reaches 63", last_slot_o, 63);
    run_tick(make_samples(seq_no));
    chk(last_slot_o == 6'd0, "R6 wraps to 0", last_slot_o, 0);
    for (int k = 0; k < 8; k++) rd_check(k, 0, model[k][0], "R6 slot 0 overwritten");
    rd_check(5, 63, model[5][63], "R7 slot 63 kept");
  endtask

  task automatic t_reset_keep;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(last_valid_o == 1'b0, "R1 valid cleared", last_valid_o, 0);
    for (int k = 0; k < 8; k++) rd_check(k, 5, model[k][5], "R9 contents survive");
    cur_slot = 0;
    run_tick(make_samples(seq_no + 100));
    chk(last_slot_o == 6'd0, "R1 pointer restarts", last_slot_o, 0);
    rd_check(2, 0, model[2][0], "R1 slot 0 rewritten");
  endtask

  initial begin
    tick_i = 1'b0;
    samples_i = '0;
    rd_ch_i = '0;
    rd_slot_i = '0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset;
    t_first_seq;
    t_ignore_tick;
    t_bypass;
    t_wrap;
    t_reset_keep;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule